// File: doc/BRIEF.md
# Data-Space Address Generator

This block forms the effective data-memory address for every load, store, push and pop issued by a small Harvard-style processor core. It takes the core's three 16-bit pointer registers and its 8-bit stack pointer, plus a direct address or a small displacement. From these it produces the address, the region of the linear data space that the address selects, and the new pointer or stack-pointer value that the core must write back.

The linear data space has three regions. The 32 working registers come first. The 64 I/O registers follow, so I/O port P sits at data address P + 0x20. A 128-byte SRAM comes after the I/O registers. Anything above the SRAM is out of range. Each access takes two clock cycles. In the first cycle a read or write strobe goes to the memory side. In the second cycle the block raises a completion pulse together with the write-back enables. The register file, the SRAM and the instruction decoder sit outside the block.

Top module: `dsagu`

## Requirements
- R1: The region output is 0 for addresses 0x0000 to 0x001F (registers), 1 for 0x0020 to 0x005F (I/O), 2 for 0x0060 to 0x00DF (SRAM), and 3 for anything higher (out of range). The `oor` output is high exactly when an accepted access has region 3.
- R2: With `op`=0 (direct), the address equals `dir_addr`. The store/load choice comes from `wr`, and nothing is written back.
- R3: With `op`=1 (plain indirect), the address equals the selected pointer. With `op`=2 (post-increment), the address equals the pointer, and the pointer written back is the pointer plus 1, modulo 2^16.
- R4: With `op`=3 (pre-decrement), both the address and the pointer written back equal the pointer minus 1, modulo 2^16.
- R5: With `op`=4 (displacement), the address equals the pointer plus the unsigned 6-bit `q`, and the pointer is not written back. This mode accepts only Y (`ptr_sel`=1) and Z (`ptr_sel`=2).
- R6: `op`=5 (push) stores to address SP and writes back SP-1. `op`=6 (pop) loads from address SP+1 and writes back SP+1. The SP arithmetic wraps at 8 bits.
- R7: An out-of-range access never asserts `mem_we`. A load to an out-of-range address still asserts `mem_re`.
- R8: A `start` seen while idle makes `busy` high for exactly two cycles. The strobe appears in the first cycle. `done`, `ptr_we` and `sp_we` appear in the second. `start` while busy is ignored.
- R9: `ptr_sel` 0, 1 and 2 select X, Y and Z. `wb_idx` gives the low register of the pair to update: 26, 28 or 30.
- R10: A rejected request (`op`=7, `ptr_sel`=3 with an indirect mode, or displacement with X) still takes two cycles. It reports region 3 with `oor` low, and raises no strobe and no write-back.
- R11: After reset, `busy`, `done`, `mem_re`, `mem_we`, `ptr_we` and `sp_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request an access (taken when idle) |
| op | input | 3 | Addressing mode, encoded as in R2 to R6 |
| wr | input | 1 | 1 = store, 0 = load (direct and indirect modes) |
| ptr_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z |
| ptr_x | input | 16 | X pointer |
| ptr_y | input | 16 | Y pointer |
| ptr_z | input | 16 | Z pointer |
| q | input | 6 | Unsigned displacement |
| dir_addr | input | 16 | Direct address |
| sp | input | 8 | Stack pointer |
| busy | output | 1 | Access in progress |
| done | output | 1 | Second (final) cycle of an access |
| addr | output | 16 | Effective address |
| region | output | 2 | Region code per R1 |
| oor | output | 1 | Out-of-range access |
| mem_re | output | 1 | Read strobe |
| mem_we | output | 1 | Write strobe |
| ptr_we | output | 1 | Pointer write-back enable |
| wb_idx | output | 5 | Low register index of the pointer pair |
| ptr_new | output | 16 | Pointer value to write back |
| sp_we | output | 1 | Stack pointer write-back enable |
| sp_new | output | 8 | Stack pointer value to write back |

## Verification
The assertions assume that the inputs are sampled only on the accepting edge. Pointer, stack and mode inputs may change freely while `busy` is high, and the block must not follow them. The assertions also assume `start` may be held across an access. The stimulus changes inputs only at falling edges and sometimes holds `start` high through a whole access. It drives pointers and SP to their wrap values and places direct addresses on each region boundary. A reference model in the bench predicts every output on every cycle.

// File: rtl/dsagu.sv
module dsagu #(
  parameter int AW       = 16,
  parameter int SPW      = 8,
  parameter int QW       = 6,
  parameter int REG_CNT  = 32,
  parameter int IO_CNT   = 64,
  parameter int SRAM_CNT = 128,
  parameter int PAIR_LO  = 26
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2:0]     op,
  input  logic           wr,
  input  logic [1:0]     ptr_sel,
  input  logic [AW-1:0]  ptr_x,
  input  logic [AW-1:0]  ptr_y,
  input  logic [AW-1:0]  ptr_z,
  input  logic [QW-1:0]  q,
  input  logic [AW-1:0]  dir_addr,
  input  logic [SPW-1:0] sp,
  output logic           busy,
  output logic           done,
  output logic [AW-1:0]  addr,
  output logic [1:0]     region,
  output logic           oor,
  output logic           mem_re,
  output logic           mem_we,
  output logic           ptr_we,
  output logic [4:0]     wb_idx,
  output logic [AW-1:0]  ptr_new,
  output logic           sp_we,
  output logic [SPW-1:0] sp_new
);
  localparam int IO_BASE   = REG_CNT;
  localparam int SRAM_BASE = REG_CNT + IO_CNT;
  localparam int TOP       = SRAM_BASE + SRAM_CNT;

  logic [1:0]     ph;
  logic           ok_q, st_q, pu_q, su_q;
  logic [AW-1:0]  ptr, a_c, pn_c;
  logic [SPW-1:0] sn_c, sp_inc;
  logic           ok_c, st_c, pu_c, su_c;
  logic [1:0]     rg_c;

  assign ptr    = (ptr_sel == 2'd0) ? ptr_x : (ptr_sel == 2'd1) ? ptr_y : ptr_z;
  assign sp_inc = sp + 1'b1;

  always_comb begin
    a_c  = ptr;
    pn_c = ptr;
    sn_c = sp;
    ok_c = (ptr_sel != 2'd3);
    st_c = wr;
    pu_c = 1'b0;
    su_c = 1'b0;
    case (op)
      3'd0: begin a_c = dir_addr; ok_c = 1'b1; end
      3'd1: ;
      3'd2: begin pn_c = ptr + 1'b1; pu_c = 1'b1; end
      3'd3: begin a_c = ptr - 1'b1; pn_c = ptr - 1'b1; pu_c = 1'b1; end
      3'd4: begin a_c = ptr + AW'(q); ok_c = (ptr_sel == 2'd1) || (ptr_sel == 2'd2); end
      3'd5: begin a_c = AW'(sp); sn_c = sp - 1'b1; su_c = 1'b1; st_c = 1'b1; ok_c = 1'b1; end
      3'd6: begin a_c = AW'(sp_inc); sn_c = sp_inc; su_c = 1'b1; st_c = 1'b0; ok_c = 1'b1; end
      default: ok_c = 1'b0;
    endcase
    if (!ok_c) rg_c = 2'd3;
    else if (a_c < AW'(IO_BASE)) rg_c = 2'd0;
    else if (a_c < AW'(SRAM_BASE)) rg_c = 2'd1;
    else if (a_c < AW'(TOP)) rg_c = 2'd2;
    else rg_c = 2'd3;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= 2'd0;
      ok_q    <= 1'b0;
      st_q    <= 1'b0;
      pu_q    <= 1'b0;
      su_q    <= 1'b0;
      addr    <= '0;
      region  <= 2'd0;
      ptr_new <= '0;
      sp_new  <= '0;
      wb_idx  <= 5'(PAIR_LO);
    end else begin
      case (ph)
        2'd0: if (start) begin
          ph      <= 2'd1;
          ok_q    <= ok_c;
          st_q    <= st_c;
          pu_q    <= pu_c & ok_c;
          su_q    <= su_c & ok_c;
          addr    <= a_c;
          region  <= rg_c;
          ptr_new <= pn_c;
          sp_new  <= sn_c;
          wb_idx  <= 5'(PAIR_LO) + {2'b0, ptr_sel, 1'b0};
        end
        2'd1:    ph <= 2'd2;
        default: ph <= 2'd0;
      endcase
    end
  end

  assign busy   = (ph != 2'd0);
  assign done   = (ph == 2'd2);
  assign oor    = busy && ok_q && (region == 2'd3);
  assign mem_re = (ph == 2'd1) && ok_q && !st_q;
  assign mem_we = (ph == 2'd1) && ok_q && st_q && (region != 2'd3);
  assign ptr_we = done && pu_q;
  assign sp_we  = done && su_q;
endmodule

module dsagu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [15:0] addr,
  input logic [1:0]  region,
  input logic        mem_re,
  input logic        mem_we,
  input logic        ptr_we,
  input logic        sp_we
);
  p_no_oor_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> region != 2'd3);
  p_second_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> done);
  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));
  p_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  p_strobe_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re || mem_we) |-> (busy && !done && !(mem_re && mem_we)));
  p_wb_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_we || sp_we) |-> done);
  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $stable(addr));
  p_reg_region_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && region == 2'd0) |-> addr < 16'h0020);
  p_one_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ptr_we && sp_we));
endmodule

bind dsagu dsagu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .addr(addr), .region(region), .mem_re(mem_re), .mem_we(mem_we),
  .ptr_we(ptr_we), .sp_we(sp_we)
);

// File: tb/tb_dsagu.sv
module tb_dsagu;
  logic clk = 0, rst_n = 0, start = 0, wr = 0;
  logic [2:0] op = 0;
  logic [1:0] ptr_sel = 0;
  logic [15:0] ptr_x = 0, ptr_y = 0, ptr_z = 0, dir_addr = 0;
  logic [5:0] q = 0;
  logic [7:0] sp = 0;
  logic busy, done, oor, mem_re, mem_we, ptr_we, sp_we;
  logic [15:0] addr, ptr_new;
  logic [1:0] region;
  logic [4:0] wb_idx;
  logic [7:0] sp_new;

  int checks = 0, errors = 0;
  int mph = 0;
  int e_addr, e_reg, e_pn, e_sn, e_idx;
  bit e_ok, e_st, e_pu, e_su;
  string tag = "R11";

  always #2.5 clk = ~clk;

  dsagu dut (.*);

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (mph=%0d)", r, act, exp, mph);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) mph = 0;
    else if (mph == 0 && start) begin
      int p;
      p = (ptr_sel == 0) ? ptr_x : (ptr_sel == 1) ? ptr_y : ptr_z;
      e_ok = (ptr_sel != 3); e_st = wr; e_pu = 0; e_su = 0; e_addr = p;
      e_pn = p; e_sn = sp; e_idx = 26 + 2 * ptr_sel;
      case (op)
        0: begin e_addr = dir_addr; e_ok = 1; end
        1: ;
        2: begin e_pn = (p + 1) % 65536; e_pu = 1; end
        3: begin e_addr = (p + 65535) % 65536; e_pn = e_addr; e_pu = 1; end
        4: begin e_addr = (p + q) % 65536; e_ok = (ptr_sel == 1 || ptr_sel == 2); end
        5: begin e_addr = sp; e_sn = (sp + 255) % 256; e_su = 1; e_st = 1; e_ok = 1; end
        6: begin e_addr = (sp + 1) % 256; e_sn = e_addr; e_su = 1; e_st = 0; e_ok = 1; end
        default: e_ok = 0;
      endcase
      if (!e_ok) e_reg = 3;
      else if (e_addr < 32) e_reg = 0;
      else if (e_addr < 96) e_reg = 1;
      else if (e_addr < 224) e_reg = 2;
      else e_reg = 3;
      e_pu = e_pu && e_ok; e_su = e_su && e_ok;
      mph = 1;
    end else if (mph == 1) mph = 2;
    else if (mph == 2) mph = 0;
  end

  always @(negedge clk) if (rst_n) begin
    chk("R8 busy", busy, mph != 0);
    chk("R8 done", done, mph == 2);
    if (mph == 0) begin
      chk("R11 mem_re idle", mem_re, 0);
      chk("R11 mem_we idle", mem_we, 0);
      chk("R11 ptr_we idle", ptr_we, 0);
      chk("R11 sp_we idle", sp_we, 0);
    end else begin
      chk({tag, " addr"}, addr, e_addr);
      chk("R1 region", region, e_reg);
      chk("R1 oor", oor, e_ok && e_reg == 3);
      chk("R7 mem_we", mem_we, mph == 1 && e_ok && e_st && e_reg != 3);
      chk({tag, " mem_re"}, mem_re, mph == 1 && e_ok && !e_st);
      chk({tag, " ptr_we"}, ptr_we, mph == 2 && e_pu);
      chk({tag, " sp_we"}, sp_we, mph == 2 && e_su);
      if (e_pu) begin
        chk({tag, " ptr_new"}, ptr_new, e_pn);
        chk("R9 wb_idx", wb_idx, e_idx);
      end
      if (e_su) chk("R6 sp_new", sp_new, e_sn);
    end
  end

  task automatic run(input string t, input int o, input bit w, input int s,
                     input int qq, input int da, input int spv, input int hold);
    @(negedge clk);
    tag = t; op = 3'(o); wr = w; ptr_sel = 2'(s); q = 6'(qq);
    dir_addr = 16'(da); sp = 8'(spv); start = 1;
    repeat (hold) @(negedge clk);
    start = 0;
    op = 3'(o + 3); ptr_x = ~ptr_x; sp = ~sp;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1;
    chk("R11 busy reset", busy, 0);
    chk("R11 mem_we reset", mem_we, 0);
    chk("R11 ptr_we reset", ptr_we, 0);
    #10 rst_n = 1;
    run("R2", 0, 1, 0, 0, 16'h001F, 0, 1);
    run("R2", 0, 1, 0, 0, 16'h0020, 0, 1);
    run("R2", 0, 0, 0, 0, 16'h005F, 0, 1);
    run("R2", 0, 1, 0, 0, 16'h0060, 0, 1);
    run("R2", 0, 1, 0, 0, 16'h00DF, 0, 1);
    run("R7", 0, 1, 0, 0, 16'h00E0, 0, 1);
    run("R7", 0, 0, 0, 0, 16'hFFFF, 0, 1);
    ptr_x = 16'hFFFF; run("R3", 2, 0, 0, 0, 0, 0, 1);
    ptr_x = 16'h0070; run("R3", 1, 1, 0, 0, 0, 0, 1);
    ptr_y = 16'h0000; run("R4", 3, 1, 1, 0, 0, 0, 1);
    ptr_z = 16'h0080; run("R4", 3, 0, 2, 0, 0, 0, 1);
    ptr_z = 16'h00A0; run("R5", 4, 0, 2, 63, 0, 0, 1);
    ptr_y = 16'h0060; run("R5", 4, 1, 1, 0, 0, 0, 1);
    ptr_x = 16'h0060; run("R10", 4, 1, 0, 5, 0, 0, 1);
    run("R10", 2, 1, 3, 0, 0, 0, 1);
    run("R10", 7, 1, 0, 0, 0, 0, 1);
    run("R6", 5, 0, 0, 0, 0, 8'h60, 1);
    run("R6", 5, 0, 0, 0, 0, 8'h00, 1);
    run("R6", 6, 1, 0, 0, 0, 8'hDF, 1);
    run("R6", 6, 1, 0, 0, 0, 8'hFF, 1);
    ptr_y = 16'h1234; run("R9", 2, 0, 1, 0, 0, 0, 3);
    ptr_z = 16'h0050; run("R8", 2, 1, 2, 0, 0, 0, 4);
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule